// File: doc/BRIEF.md
# Checkpointed Register File with Commit and Rollback

This block is a multi-ported general-purpose register file in which every architectural register has two storage copies. One is a working copy that instruction results update. The other is a checkpoint copy that holds the state as of the last successful commit. Four write ports and eight read ports let a wide-issue core retire several operations each cycle against the working copies. The checkpoint copies are never touched by these writes.

When a translated code region finishes cleanly, the core pulses `commit_req`. In one cycle the whole working set is copied into the checkpoint set. Faults, exceptions, failed speculation and interrupts all reach the block as `rollback_req`. In one cycle that request replaces the whole working set with the checkpoint set, and it discards any writes issued in the same cycle.

Register accesses are plain per-cycle control with no valid/ready handshake. Every enabled write is taken at the next rising edge, and every read returns data combinationally in the same cycle. Back-pressure is not possible, so the issuing logic never has to stall for this block. A debug port reads any checkpoint register combinationally.

Top module: `cprf_top`

## Requirements
- R1: After reset (active-low `rst_n`), every working copy and every checkpoint copy reads as zero.
- R2: An enabled write updates only the working copy of its target register at the next rising edge. A write never alters a checkpoint copy.
- R3: When `rollback_req` is high at a rising edge, every working register takes the value of its checkpoint copy at that edge.
- R4: When `commit_req` is high and `rollback_req` is low at a rising edge, every checkpoint register takes the working value produced at that same edge. That value includes the writes made in the commit cycle.
- R5: When `commit_req` and `rollback_req` are both high, the rollback is carried out and the checkpoint set keeps its previous contents.
- R6: Writes presented in a rollback cycle are discarded. After the edge, the working set equals the checkpoint set exactly.
- R7: Read port p returns the working copy of register `rd_addr[p]`. If an enabled write targets that register in the same cycle and no rollback is requested, the port returns the write data instead (bypass).
- R8: When several enabled write ports target the same register in one cycle, the highest-numbered port's data is stored, and that same data is bypassed to reads.
- R9: All eight read ports and all four write ports operate independently in the same cycle.
- R10: `dbg_data` returns, combinationally, the checkpoint copy of register `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 8x5 | Register index for each read port |
| rd_data | output | 8x32 | Read data for each read port |
| wr_en | input | 4 | Write enable for each write port |
| wr_addr | input | 4x5 | Target register index for each write port |
| wr_data | input | 4x32 | Write data for each write port |
| commit_req | input | 1 | Copy the working set into the checkpoint set |
| rollback_req | input | 1 | Restore the working set from the checkpoint set |
| dbg_addr | input | 5 | Checkpoint register to observe |
| dbg_data | output | 32 | Checkpoint copy of `dbg_addr` |

## Verification
The assertions check on every cycle that the whole-file transfers behave as specified. A rollback leaves the working set equal to the previous checkpoint set. A commit leaves the two sets identical. The checkpoint set holds still whenever no winning commit occurs. The top write port's data is bypassed to read port 0. Other properties need the bench's scenarios: that port priority holds for every port pair, that writes made in a commit cycle land in the checkpoint, and that values survive long chains of writes, commits and rollbacks. These are shown by comparing every read port and the debug port each cycle against a bench model.

// File: rtl/cprf_pkg.sv
package cprf_pkg;
  localparam int unsigned DEF_NREG  = 32;
  localparam int unsigned DEF_WIDTH = 32;
  localparam int unsigned DEF_NRD   = 8;
  localparam int unsigned DEF_NWR   = 4;
endpackage

// File: rtl/cprf_wr_merge.sv
// Resolves the write ports into one next-value per register.
// A later (higher-numbered) port overrides earlier ones; everything is
// suppressed while a rollback is requested.
module cprf_wr_merge #(
  parameter int unsigned NREG  = cprf_pkg::DEF_NREG,
  parameter int unsigned WIDTH = cprf_pkg::DEF_WIDTH,
  parameter int unsigned NWR   = cprf_pkg::DEF_NWR,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic [NWR-1:0]             wr_en,
  input  logic [NWR-1:0][AW-1:0]     wr_addr,
  input  logic [NWR-1:0][WIDTH-1:0]  wr_data,
  input  logic                       block,
  output logic [NREG-1:0]            hit,
  output logic [NREG-1:0][WIDTH-1:0] val
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_comb begin
      hit[r] = 1'b0;
      val[r] = '0;
      for (int p = 0; p < NWR; p++) begin
        if (wr_en[p] && (wr_addr[p] == AW'(r)) && !block) begin
          hit[r] = 1'b1;
          val[r] = wr_data[p];
        end
      end
    end
  end
endmodule

// File: rtl/cprf_rd_port.sv
// One read port: working copy, or the same-cycle winning write.
module cprf_rd_port #(
  parameter int unsigned NREG  = cprf_pkg::DEF_NREG,
  parameter int unsigned WIDTH = cprf_pkg::DEF_WIDTH,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic [AW-1:0]              addr,
  input  logic [NREG-1:0][WIDTH-1:0] work,
  input  logic [NREG-1:0]            hit,
  input  logic [NREG-1:0][WIDTH-1:0] val,
  output logic [WIDTH-1:0]           data
);
  always_comb data = hit[addr] ? val[addr] : work[addr];
endmodule

// File: rtl/cprf_top.sv
module cprf_top #(
  parameter int unsigned NREG  = cprf_pkg::DEF_NREG,
  parameter int unsigned WIDTH = cprf_pkg::DEF_WIDTH,
  parameter int unsigned NRD   = cprf_pkg::DEF_NRD,
  parameter int unsigned NWR   = cprf_pkg::DEF_NWR,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][WIDTH-1:0] rd_data,
  input  logic [NWR-1:0]            wr_en,
  input  logic [NWR-1:0][AW-1:0]    wr_addr,
  input  logic [NWR-1:0][WIDTH-1:0] wr_data,
  input  logic                      commit_req,
  input  logic                      rollback_req,
  input  logic [AW-1:0]             dbg_addr,
  output logic [WIDTH-1:0]          dbg_data
);
  logic [NREG-1:0][WIDTH-1:0] work_q;
  logic [NREG-1:0][WIDTH-1:0] shadow_q;
  logic [NREG-1:0]            wr_hit;
  logic [NREG-1:0][WIDTH-1:0] wr_val;

  cprf_wr_merge #(.NREG(NREG), .WIDTH(WIDTH), .NWR(NWR)) u_merge (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .block  (rollback_req),
    .hit    (wr_hit),
    .val    (wr_val)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    cprf_rd_port #(.NREG(NREG), .WIDTH(WIDTH)) u_rd (
      .addr(rd_addr[p]),
      .work(work_q),
      .hit (wr_hit),
      .val (wr_val),
      .data(rd_data[p])
    );
  end

  always_comb dbg_data = shadow_q[dbg_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q   <= '0;
      shadow_q <= '0;
    end else if (rollback_req) begin
      work_q <= shadow_q;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_hit[r]) work_q[r] <= wr_val[r];
        if (commit_req) shadow_q[r] <= wr_hit[r] ? wr_val[r] : work_q[r];
      end
    end
  end
endmodule

// File: rtl/cprf_checker.sv
module cprf_checker #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NRD   = 8,
  parameter int unsigned NWR   = 4,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NRD-1:0][AW-1:0]     rd_addr,
  input logic [NRD-1:0][WIDTH-1:0]  rd_data,
  input logic [NWR-1:0]             wr_en,
  input logic [NWR-1:0][AW-1:0]     wr_addr,
  input logic [NWR-1:0][WIDTH-1:0]  wr_data,
  input logic                       commit_req,
  input logic                       rollback_req,
  input logic [NREG-1:0][WIDTH-1:0] work_q,
  input logic [NREG-1:0][WIDTH-1:0] shadow_q
);
  // R3 / R6: working set equals the prior checkpoint after a rollback
  a_r3_rollback_restores: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_req |=> work_q == $past(shadow_q));

  // R5: rollback beats commit, checkpoint untouched
  a_r5_rollback_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_req |=> shadow_q == $past(shadow_q));

  // R2: without a winning commit the checkpoint set holds
  a_r2_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_req |=> shadow_q == $past(shadow_q));

  // R4: after a winning commit both copies agree
  a_r4_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !rollback_req) |=> shadow_q == work_q);

  // R7 / R8: top write port is bypassed to read port 0
  a_r7_bypass_top_port: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[NWR-1] && wr_addr[NWR-1] == rd_addr[0] && !rollback_req)
      |-> rd_data[0] == wr_data[NWR-1]);
endmodule

bind cprf_top cprf_checker #(.NREG(NREG), .WIDTH(WIDTH), .NRD(NRD), .NWR(NWR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .commit_req(commit_req), .rollback_req(rollback_req),
  .work_q(work_q), .shadow_q(shadow_q)
);

// File: tb/test_cprf_top.sv
module test_cprf_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32, W = 32, NRD = 8, NWR = 4, AW = 5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NRD-1:0][AW-1:0] rd_addr = '0;
  logic [NRD-1:0][W-1:0]  rd_data;
  logic [NWR-1:0]         wr_en = '0;
  logic [NWR-1:0][AW-1:0] wr_addr = '0;
  logic [NWR-1:0][W-1:0]  wr_data = '0;
  logic                   commit_req = 1'b0;
  logic                   rollback_req = 1'b0;
  logic [AW-1:0]          dbg_addr = '0;
  logic [W-1:0]           dbg_data;

  logic [W-1:0] mw [NREG];
  logic [W-1:0] ms [NREG];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cprf_top i_cprf_top (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .rollback_req(rollback_req),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
    logic [W-1:0] v = mw[a];
    if (!rollback_req)
      for (int p = 0; p < NWR; p++)
        if (wr_en[p] && wr_addr[p] == a) v = wr_data[p];
    return v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_update();
    if (rollback_req) begin
      for (int r = 0; r < NREG; r++) mw[r] = ms[r];
    end else begin
      for (int p = 0; p < NWR; p++) if (wr_en[p]) mw[wr_addr[p]] = wr_data[p];
      if (commit_req) for (int r = 0; r < NREG; r++) ms[r] = mw[r];
    end
  endtask

  // checks all ports against the model, then advances one clock
  task automatic run_cycle(input string req);
    #2;
    for (int p = 0; p < NRD; p++) chk(req, rd_data[p], exp_read(rd_addr[p]));
    chk(req, dbg_data, ms[dbg_addr]);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = '0; commit_req = 1'b0; rollback_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int r = 0; r < NREG; r++) begin mw[r] = '0; ms[r] = '0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of both copies
    for (int r = 0; r < NREG; r++) begin
      rd_addr[0] = AW'(r); dbg_addr = AW'(r);
      #2; chk("R1", rd_data[0], '0); chk("R1", dbg_data, '0);
      run_cycle("R1");
    end

    // R2: write touches working copy only
    wr_en = 4'b0001; wr_addr[0] = 5'd3; wr_data[0] = 32'hA5A5_0003;
    rd_addr[1] = 5'd3; dbg_addr = 5'd3;
    run_cycle("R2");
    idle();
    #2; chk("R2", rd_data[1], 32'hA5A5_0003); chk("R2", dbg_data, 32'h0);
    run_cycle("R2");

    // R8: ports 0 and 3 hit register 5, port 3 wins (bypass and storage)
    wr_en = 4'b1001; wr_addr[0] = 5'd5; wr_data[0] = 32'h1111_1111;
    wr_addr[3] = 5'd5; wr_data[3] = 32'h3333_3333; rd_addr[0] = 5'd5;
    #2; chk("R8", rd_data[0], 32'h3333_3333);
    run_cycle("R8");
    idle();
    #2; chk("R8", rd_data[0], 32'h3333_3333);
    // R8: ports 1 and 2 collide, port 2 wins
    wr_en = 4'b0110; wr_addr[1] = 5'd7; wr_data[1] = 32'h2222_0001;
    wr_addr[2] = 5'd7; wr_data[2] = 32'h2222_0002; rd_addr[2] = 5'd7;
    #2; chk("R8", rd_data[2], 32'h2222_0002);
    run_cycle("R8");
    idle();

    // R4: commit with same-cycle write lands in checkpoint
    wr_en = 4'b0010; wr_addr[1] = 5'd9; wr_data[1] = 32'hC0DE_0009; commit_req = 1'b1;
    run_cycle("R4");
    idle(); dbg_addr = 5'd9;
    #2; chk("R4", dbg_data, 32'hC0DE_0009);
    dbg_addr = 5'd5; #1; chk("R4", dbg_data, 32'h3333_3333);
    run_cycle("R4");

    // R3: modify then roll back
    wr_en = 4'b0001; wr_addr[0] = 5'd9; wr_data[0] = 32'hDEAD_BEEF;
    run_cycle("R3");
    idle(); rollback_req = 1'b1;
    run_cycle("R3");
    idle(); rd_addr[3] = 5'd9;
    #2; chk("R3", rd_data[3], 32'hC0DE_0009);
    run_cycle("R3");

    // R6 / R7: writes in rollback cycle dropped, no bypass
    wr_en = 4'b1111; rollback_req = 1'b1;
    for (int p = 0; p < NWR; p++) begin wr_addr[p] = 5'd9; wr_data[p] = 32'hBAD0_0000 + p; end
    rd_addr[4] = 5'd9;
    #2; chk("R6", rd_data[4], 32'hC0DE_0009);
    run_cycle("R6");
    idle();
    #2; chk("R6", rd_data[4], 32'hC0DE_0009);
    run_cycle("R6");

    // R5: commit and rollback together, checkpoint unchanged
    wr_en = 4'b0001; wr_addr[0] = 5'd12; wr_data[0] = 32'h0000_0C0C;
    run_cycle("R5");
    idle(); commit_req = 1'b1; rollback_req = 1'b1; dbg_addr = 5'd12; rd_addr[5] = 5'd12;
    run_cycle("R5");
    idle();
    #2; chk("R5", dbg_data, 32'h0); chk("R5", rd_data[5], 32'h0);
    run_cycle("R5");

    // R9 / R10: random traffic, narrow address range often for collisions
    for (int c = 0; c < 3000; c++) begin
      bit narrow = ($urandom % 2) == 0;
      for (int p = 0; p < NRD; p++) rd_addr[p] = AW'(narrow ? $urandom % 4 : $urandom);
      for (int p = 0; p < NWR; p++) begin
        wr_en[p] = ($urandom % 2) == 0;
        wr_addr[p] = AW'(narrow ? $urandom % 4 : $urandom);
        wr_data[p] = $urandom;
      end
      commit_req = ($urandom % 8) == 0;
      rollback_req = ($urandom % 16) == 0;
      dbg_addr = AW'($urandom);
      run_cycle("R9/R10");
    end
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule